// File: doc/BRIEF.md
# Inbound Request Address Decoder and Chunk Splitter

This block sits behind a packet-based hub link and works out where each inbound request goes. A request has a kind (memory read, memory write or I/O), a start address, a length from 1 to 256 bytes, and a flag saying whether a write expects a completion. The block compares addresses against a set of configured windows:

- main memory, from zero up to a top address;
- a protected system-management region;
- a graphics aperture, given as a base and a size;
- two downstream graphics-port windows, each given as a base and a limit;
- the legacy VGA range.

From this comparison it decides which device, if any, owns each part of the request.

Each request is cut into naturally aligned chunks of 32 or 64 bytes and issued one chunk per cycle, in ascending address order, over a valid/ready handshake. For each chunk the block gives:

- the target device;
- the address to use;
- per-byte enables;
- a completion status;
- a snoop flag;
- an all-ones read-data flag;
- a last-chunk marker.

The device that owns the start address owns the request. Chunks that land on another device, or on no device, are not rejected. They become harmless dummy accesses to address zero in main memory.

The state machine has two states. S_IDLE holds `req_ready` high. Accepting a request (transition IDLE_TO_ISSUE) latches it and decodes its start address. S_ISSUE presents the current chunk and has three transitions:

- ISSUE_STALL: `out_ready` is low, so the chunk is held.
- ISSUE_NEXT: a non-final chunk is taken, and the block moves to the next aligned boundary.
- ISSUE_DONE: the final chunk is taken, and the block returns to S_IDLE.

Top module: `hub_req_splitter`

## Requirements
- R1: An I/O request (kind 2) is refused. Each of its chunks has snoop 1, address 0, target main memory (target 0), byte enables all 0 and status master abort (status 1).
- R2: Memory reads (kind 0) and writes (kind 1) at or below the main-memory top address go to main memory (target 0) at their own address. A read reports status 0 (ok).
- R3: An access inside the system-management window (inclusive base and limit) is invalid, even though that window lies below the main-memory top.
- R4: The aperture covers base through base+size-1 and maps to main memory (target 0). It is disabled when its size is zero.
- R5: The graphics-port windows (inclusive base and limit) accept writes only, with target 1. Reads that hit them are invalid.
- R6: A write in 0xA0000–0xBFFFF goes to the graphics port (target 1) only while the VGA enable is 1. Otherwise the range decodes like any other address. Priority runs: management region, aperture, graphics-port windows, VGA, main memory.
- R7: Chunks are naturally aligned: 64 bytes when `cfg_chunk64` is 1, otherwise 32. They are issued in ascending order. The first chunk's address is the request start and each later chunk's address is its aligned base. `out_be` bit i stands for byte (aligned base + i) and is set only for bytes that the request covers. `out_last` marks the final chunk.
- R8: Once the start is valid, a chunk that decodes to a different device, or to no device, is remapped: address 0, target 0, snoop 1.
- R9: If the start address is invalid, every chunk of the request is remapped.
- R10: Status codes are 0 (ok), 1 (master abort) and 2 (no completion).
  - An invalid read keeps its byte enables, raises `out_ones` and reports status 1.
  - An invalid write clears all byte enables and reports 1 if a completion was asked for, otherwise 2.
  - A valid write reports 0 if a completion was asked for, otherwise 2.
- R11: A stalled chunk holds all of its outputs unchanged. A new request is accepted only in S_IDLE, and never while a chunk is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle (S_IDLE) |
| req_kind | input | 2 | 0 memory read, 1 memory write, 2 I/O |
| req_addr | input | AW | Start byte address |
| req_len | input | $clog2(MAX_LEN)+1 | Length in bytes, 1..MAX_LEN |
| req_cpl | input | 1 | Write expects a completion |
| cfg_chunk64 | input | 1 | 1: 64-byte chunks, 0: 32-byte chunks |
| cfg_mem_top | input | AW | Highest main-memory byte address |
| cfg_smm_base | input | AW | Management region first byte |
| cfg_smm_limit | input | AW | Management region last byte |
| cfg_ap_base | input | AW | Aperture first byte |
| cfg_ap_size | input | AW | Aperture size in bytes, 0 disables |
| cfg_gp_base | input | AW | Graphics-port window first byte |
| cfg_gp_limit | input | AW | Graphics-port window last byte |
| cfg_gpp_base | input | AW | Prefetchable graphics-port window first byte |
| cfg_gpp_limit | input | AW | Prefetchable graphics-port window last byte |
| cfg_vga_en | input | 1 | Forward VGA-range writes to the graphics port |
| out_valid | output | 1 | Chunk presented |
| out_ready | input | 1 | Chunk taken |
| out_target | output | 2 | 0 main memory, 1 graphics port |
| out_addr | output | AW | Chunk address (0 when remapped) |
| out_be | output | CHUNK_MAX | Byte enables, bit i = aligned base + i |
| out_status | output | 2 | 0 ok, 1 master abort, 2 no completion |
| out_snoop | output | 1 | Remapped dummy access, snoop required |
| out_ones | output | 1 | Return all-ones read data |
| out_last | output | 1 | Final chunk of the request |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 64-byte maximum chunk and 256-byte requests. It switches `cfg_chunk64` at run time, so that one build covers both chunk sizes.

With these values, a 256-byte unaligned request in 32-byte mode reaches nine chunks, with partial enables at both ends. The windows are placed so that a single request can step past the main-memory top, the aperture's inclusive end or a graphics-port limit. This brings both kinds of remapping within reach: the remapping of a chunk after a valid start, and the remapping of a whole request after an invalid start.

// File: rtl/hub_split_pkg.sv
package hub_split_pkg;

    typedef enum logic [1:0] {
        K_MRD = 2'd0,
        K_MWR = 2'd1,
        K_IO  = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        DEV_DRAM  = 2'd0,
        DEV_GPORT = 2'd1,
        DEV_NONE  = 2'd2
    } dev_e;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_MABORT = 2'd1,
        ST_NOCPL  = 2'd2
    } cpl_st_e;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_ISSUE = 1'b1
    } split_state_e;

    localparam logic [31:0] VGA_LO = 32'h000A_0000;
    localparam logic [31:0] VGA_HI = 32'h000B_FFFF;

endpackage

// File: rtl/hub_addr_decode.sv
module hub_addr_decode
    import hub_split_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    kind,
    input  logic [AW-1:0] cfg_mem_top,
    input  logic [AW-1:0] cfg_smm_base,
    input  logic [AW-1:0] cfg_smm_limit,
    input  logic [AW-1:0] cfg_ap_base,
    input  logic [AW-1:0] cfg_ap_size,
    input  logic [AW-1:0] cfg_gp_base,
    input  logic [AW-1:0] cfg_gp_limit,
    input  logic [AW-1:0] cfg_gpp_base,
    input  logic [AW-1:0] cfg_gpp_limit,
    input  logic          cfg_vga_en,
    output dev_e          dev
);

    localparam logic [AW-1:0] VGA_FIRST = AW'(VGA_LO);
    localparam logic [AW-1:0] VGA_FINAL = AW'(VGA_HI);

    logic [AW-1:0] ap_last;
    logic          is_io, is_wr;
    logic          hit_smm, hit_ap, hit_gp, hit_vga, hit_mem;

    always_comb begin
        ap_last = cfg_ap_base + cfg_ap_size - AW'(1);
        is_io   = (kind == K_IO);
        is_wr   = (kind == K_MWR);
        hit_smm = (addr >= cfg_smm_base) && (addr <= cfg_smm_limit);
        hit_ap  = (cfg_ap_size != '0) && (addr >= cfg_ap_base) && (addr <= ap_last);
        hit_gp  = ((addr >= cfg_gp_base) && (addr <= cfg_gp_limit)) ||
                  ((addr >= cfg_gpp_base) && (addr <= cfg_gpp_limit));
        hit_vga = cfg_vga_en && is_wr && (addr >= VGA_FIRST) && (addr <= VGA_FINAL);
        hit_mem = (addr <= cfg_mem_top);
    end

    always_comb begin
        if (is_io)        dev = DEV_NONE;
        else if (hit_smm) dev = DEV_NONE;
        else if (hit_ap)  dev = DEV_DRAM;
        else if (hit_gp)  dev = is_wr ? DEV_GPORT : DEV_NONE;
        else if (hit_vga) dev = DEV_GPORT;
        else if (hit_mem) dev = DEV_DRAM;
        else              dev = DEV_NONE;
    end

endmodule

// File: rtl/hub_chunk_calc.sv
module hub_chunk_calc #(
    parameter int AW        = 32,
    parameter int CHUNK_MAX = 64
) (
    input  logic [AW-1:0]        cur_addr,
    input  logic [AW:0]          end_excl,
    input  logic                 big,
    output logic [CHUNK_MAX-1:0] be,
    output logic                 is_last,
    output logic [AW-1:0]        next_addr
);

    localparam int OW    = $clog2(CHUNK_MAX) + 1;
    localparam int SMALL = CHUNK_MAX / 2;
    localparam int AW1   = AW + 1;

    logic [AW-1:0] mask, base;
    logic [OW-1:0] size, lo_off, hi_off;
    logic [AW:0]   chunk_end, span;

    always_comb begin
        mask      = big ? AW'(CHUNK_MAX - 1) : AW'(SMALL - 1);
        size      = big ? OW'(CHUNK_MAX) : OW'(SMALL);
        base      = cur_addr & ~mask;
        chunk_end = {1'b0, base} + AW1'(size);
        is_last   = (end_excl <= chunk_end);
        span      = end_excl - {1'b0, base};
        lo_off    = OW'(cur_addr & mask);
        hi_off    = is_last ? OW'(span) : size;
        next_addr = chunk_end[AW-1:0];
    end

    for (genvar i = 0; i < CHUNK_MAX; i++) begin : g_byte
        localparam logic [OW-1:0] IDX = OW'(i);
        assign be[i] = (IDX >= lo_off) && (IDX < hi_off);
    end

endmodule

// File: rtl/hub_req_splitter.sv
module hub_req_splitter
    import hub_split_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CHUNK_MAX = 64,
    parameter int MAX_LEN   = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_kind,
    input  logic [AW-1:0]                req_addr,
    input  logic [$clog2(MAX_LEN):0]     req_len,
    input  logic                         req_cpl,
    input  logic                         cfg_chunk64,
    input  logic [AW-1:0]                cfg_mem_top,
    input  logic [AW-1:0]                cfg_smm_base,
    input  logic [AW-1:0]                cfg_smm_limit,
    input  logic [AW-1:0]                cfg_ap_base,
    input  logic [AW-1:0]                cfg_ap_size,
    input  logic [AW-1:0]                cfg_gp_base,
    input  logic [AW-1:0]                cfg_gp_limit,
    input  logic [AW-1:0]                cfg_gpp_base,
    input  logic [AW-1:0]                cfg_gpp_limit,
    input  logic                         cfg_vga_en,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [1:0]                   out_target,
    output logic [AW-1:0]                out_addr,
    output logic [CHUNK_MAX-1:0]         out_be,
    output logic [1:0]                   out_status,
    output logic                         out_snoop,
    output logic                         out_ones,
    output logic                         out_last
);

    localparam int AW1 = AW + 1;

    split_state_e         state, state_nx;
    logic [AW-1:0]        cur_addr;
    logic [AW:0]          end_excl;
    req_kind_e            kind_q;
    logic                 cpl_q;
    dev_e                 start_dev_q;

    logic [AW-1:0]        dec_addr;
    logic [1:0]           dec_kind;
    dev_e                 dec_dev;
    logic [CHUNK_MAX-1:0] calc_be;
    logic                 calc_last;
    logic [AW-1:0]        calc_next;
    logic                 take_req, take_chunk, chunk_good;

    assign dec_addr   = (state == S_IDLE) ? req_addr : cur_addr;
    assign dec_kind   = (state == S_IDLE) ? req_kind : kind_q;
    assign take_req   = (state == S_IDLE) && req_valid;
    assign take_chunk = (state == S_ISSUE) && out_ready;

    hub_addr_decode #(.AW(AW)) u_decode (
        .addr          (dec_addr),
        .kind          (dec_kind),
        .cfg_mem_top   (cfg_mem_top),
        .cfg_smm_base  (cfg_smm_base),
        .cfg_smm_limit (cfg_smm_limit),
        .cfg_ap_base   (cfg_ap_base),
        .cfg_ap_size   (cfg_ap_size),
        .cfg_gp_base   (cfg_gp_base),
        .cfg_gp_limit  (cfg_gp_limit),
        .cfg_gpp_base  (cfg_gpp_base),
        .cfg_gpp_limit (cfg_gpp_limit),
        .cfg_vga_en    (cfg_vga_en),
        .dev           (dec_dev)
    );

    hub_chunk_calc #(.AW(AW), .CHUNK_MAX(CHUNK_MAX)) u_chunk (
        .cur_addr  (cur_addr),
        .end_excl  (end_excl),
        .big       (cfg_chunk64),
        .be        (calc_be),
        .is_last   (calc_last),
        .next_addr (calc_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transitions: IDLE_TO_ISSUE, ISSUE_STALL, ISSUE_NEXT, ISSUE_DONE
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (take_req) state_nx = S_ISSUE;
            S_ISSUE: if (take_chunk && calc_last) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Request context and chunk pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr    <= '0;
            end_excl    <= '0;
            kind_q      <= K_MRD;
            cpl_q       <= 1'b0;
            start_dev_q <= DEV_NONE;
        end else if (take_req) begin
            cur_addr    <= req_addr;
            end_excl    <= {1'b0, req_addr} + AW1'(req_len);
            kind_q      <= req_kind_e'(req_kind);
            cpl_q       <= req_cpl;
            start_dev_q <= dec_dev;
        end else if (take_chunk && !calc_last) begin
            cur_addr    <= calc_next;
        end
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        out_valid  = 1'b0;
        out_target = DEV_DRAM;
        out_addr   = '0;
        out_be     = '0;
        out_status = ST_OK;
        out_snoop  = 1'b0;
        out_ones   = 1'b0;
        out_last   = 1'b0;
        chunk_good = (kind_q != K_IO) && (start_dev_q != DEV_NONE) &&
                     (dec_dev == start_dev_q);
        unique case (state)
            S_IDLE: req_ready = 1'b1;
            S_ISSUE: begin
                out_valid = 1'b1;
                out_last  = calc_last;
                if (chunk_good) begin
                    out_target = start_dev_q;
                    out_addr   = cur_addr;
                    out_be     = calc_be;
                    if (kind_q == K_MWR && !cpl_q) out_status = ST_NOCPL;
                    else                           out_status = ST_OK;
                end else begin
                    out_snoop = 1'b1;
                    out_ones  = (kind_q == K_MRD);
                    out_be    = (kind_q == K_MRD) ? calc_be : '0;
                    if (kind_q == K_MWR && !cpl_q) out_status = ST_NOCPL;
                    else                           out_status = ST_MABORT;
                end
            end
            default: req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/hub_req_splitter_chk.sv
module hub_req_splitter_chk #(
    parameter int AW        = 32,
    parameter int CHUNK_MAX = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [1:0]           req_kind,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [1:0]           out_target,
    input logic [AW-1:0]        out_addr,
    input logic [CHUNK_MAX-1:0] out_be,
    input logic [1:0]           out_status,
    input logic                 out_snoop,
    input logic                 out_ones,
    input logic                 out_last
);

    logic [1:0] kind_seen;
    logic       first_q, bad_start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_seen <= 2'd0;
            first_q   <= 1'b0;
            bad_start <= 1'b0;
        end else if (req_valid && req_ready) begin
            kind_seen <= req_kind;
            first_q   <= 1'b1;
            bad_start <= 1'b0;
        end else if (out_valid && out_ready) begin
            first_q <= 1'b0;
            if (first_q) bad_start <= out_snoop;
        end
    end

    p_io_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && kind_seen == 2'd2 |-> out_snoop && out_status == 2'd1 && out_be == '0);

    p_remap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_snoop |-> out_addr == '0 && out_target == 2'd0);

    p_whole_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !first_q && bad_start |-> out_snoop);

    p_wr_be_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_snoop && kind_seen == 2'd1 |-> out_be == '0);

    p_ones_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ones |-> out_snoop && out_status == 2'd1);

    p_be_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_snoop |-> out_be != '0);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_be)
                                    && $stable(out_last) && $stable(out_status));

    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

endmodule

bind hub_req_splitter hub_req_splitter_chk #(.AW(AW), .CHUNK_MAX(CHUNK_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_kind   (req_kind),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_target (out_target),
    .out_addr   (out_addr),
    .out_be     (out_be),
    .out_status (out_status),
    .out_snoop  (out_snoop),
    .out_ones   (out_ones),
    .out_last   (out_last)
);

// File: tb/tb_hub_req_splitter.sv
`timescale 1ns/1ps
module tb_hub_req_splitter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [31:0] req_addr = '0;
    logic [8:0]  req_len = 9'd1;
    logic        req_cpl = 1'b0;
    logic        cfg_chunk64 = 1'b1;
    logic [31:0] cfg_mem_top   = 32'h0FFF_FFFF;
    logic [31:0] cfg_smm_base  = 32'h0F00_0000;
    logic [31:0] cfg_smm_limit = 32'h0F0F_FFFF;
    logic [31:0] cfg_ap_base   = 32'h4000_0000;
    logic [31:0] cfg_ap_size   = 32'h0100_0000;
    logic [31:0] cfg_gp_base   = 32'h8000_0000;
    logic [31:0] cfg_gp_limit  = 32'h80FF_FFFF;
    logic [31:0] cfg_gpp_base  = 32'h9000_0000;
    logic [31:0] cfg_gpp_limit = 32'h90FF_FFFF;
    logic        cfg_vga_en = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [1:0]  out_target;
    logic [31:0] out_addr;
    logic [63:0] out_be;
    logic [1:0]  out_status;
    logic        out_snoop, out_ones, out_last;

    int checks = 0;
    int errors = 0;

    logic [31:0] c_addr [16];
    logic [63:0] c_be   [16];
    logic [1:0]  c_tgt  [16];
    logic [1:0]  c_st   [16];
    logic        c_snp  [16];
    logic        c_ones [16];
    logic        c_last [16];
    int          n;

    always #4 clk = ~clk;

    hub_req_splitter dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_len(req_len), .req_cpl(req_cpl),
        .cfg_chunk64(cfg_chunk64), .cfg_mem_top(cfg_mem_top),
        .cfg_smm_base(cfg_smm_base), .cfg_smm_limit(cfg_smm_limit),
        .cfg_ap_base(cfg_ap_base), .cfg_ap_size(cfg_ap_size),
        .cfg_gp_base(cfg_gp_base), .cfg_gp_limit(cfg_gp_limit),
        .cfg_gpp_base(cfg_gpp_base), .cfg_gpp_limit(cfg_gpp_limit),
        .cfg_vga_en(cfg_vga_en),
        .out_valid(out_valid), .out_ready(out_ready), .out_target(out_target),
        .out_addr(out_addr), .out_be(out_be), .out_status(out_status),
        .out_snoop(out_snoop), .out_ones(out_ones), .out_last(out_last)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected enables: bit i is byte (aligned base + i), set when covered
    function automatic logic [63:0] exp_be(input logic [31:0] cur, input logic [32:0] endx,
                                           input int csz);
        logic [31:0] base;
        logic [63:0] r;
        base = cur & ~(32'(csz) - 32'd1);
        r = '0;
        for (int i = 0; i < csz; i++)
            if ((33'(base) + 33'(i) >= 33'(cur)) && (33'(base) + 33'(i) < endx)) r[i] = 1'b1;
        return r;
    endfunction

    task automatic send(input logic [1:0] kind, input logic [31:0] addr,
                        input int len, input logic cpl, input int stall);
        int guard;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr;
        req_len = 9'(len); req_cpl = cpl;
        if (stall > 0) out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        guard = 0;
        while (guard < 64) begin
            guard++;
            if (out_valid) begin
                if (stall > 0 && n == 0) begin
                    for (int s = 0; s < stall; s++) begin
                        @(negedge clk);
                        chk("R11 stalled chunk held", {31'd0, out_valid, out_addr}, {32'd1, addr});
                        chk("R11 no accept while busy", 64'(req_ready), 64'd0);
                    end
                    out_ready = 1'b1;
                end
                c_addr[n] = out_addr; c_be[n] = out_be; c_tgt[n] = out_target;
                c_st[n] = out_status; c_snp[n] = out_snoop; c_ones[n] = out_ones;
                c_last[n] = out_last;
                n++;
                if (out_last || n == 16) break;
            end
            @(negedge clk);
        end
        if (guard >= 64) chk("R7 request completed", 64'd0, 64'd1);
    endtask

    task automatic chunk(input string tag, input int i, input logic [31:0] a,
                         input logic [63:0] be, input logic [1:0] tgt, input logic [1:0] st,
                         input logic snp, input logic ones, input logic last);
        chk({tag, " addr"}, 64'(c_addr[i]), 64'(a));
        chk({tag, " be"}, c_be[i], be);
        chk({tag, " flags"}, {56'd0, c_tgt[i], c_st[i], c_snp[i], c_ones[i], c_last[i], 1'b0},
            {56'd0, tgt, st, snp, ones, last, 1'b0});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11 reset out_valid", 64'(out_valid), 64'd0);
        chk("R11 reset req_ready", 64'(req_ready), 64'd1);
    endtask

    task automatic t_main_mem;
        cfg_chunk64 = 1'b1;
        send(2'd0, 32'h0000_1000, 64, 1'b0, 0);
        chk("R2 count", 64'(n), 64'd1);
        chunk("R2 aligned read", 0, 32'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 2'd0, 0, 0, 1);
        cfg_chunk64 = 1'b0;
        send(2'd0, 32'h0000_1010, 48, 1'b0, 0);
        chk("R7 count", 64'(n), 64'd2);
        chunk("R7 partial head", 0, 32'h1010, exp_be(32'h1010, 33'h1040, 32), 2'd0, 2'd0, 0, 0, 0);
        chunk("R7 full tail", 1, 32'h1020, 64'hFFFF_FFFF, 2'd0, 2'd0, 0, 0, 1);
    endtask

    task automatic t_cross;
        cfg_chunk64 = 1'b0;
        send(2'd1, 32'h0FFF_FFE0, 64, 1'b1, 0);
        chk("R8 count", 64'(n), 64'd2);
        chunk("R8 valid head", 0, 32'h0FFF_FFE0, 64'hFFFF_FFFF, 2'd0, 2'd0, 0, 0, 0);
        chunk("R8 remapped write cpl", 1, 0, 0, 2'd0, 2'd1, 1, 0, 1);
        send(2'd1, 32'h80FF_FFE0, 64, 1'b0, 0);
        chunk("R5 gport posted head", 0, 32'h80FF_FFE0, 64'hFFFF_FFFF, 2'd1, 2'd2, 0, 0, 0);
        chunk("R10 remapped posted write", 1, 0, 0, 2'd0, 2'd2, 1, 0, 1);
        send(2'd0, 32'h40FF_FFE0, 64, 1'b0, 0);
        chunk("R4 aperture last bytes", 0, 32'h40FF_FFE0, 64'hFFFF_FFFF, 2'd0, 2'd0, 0, 0, 0);
        chunk("R8 past aperture read", 1, 0, 64'hFFFF_FFFF, 2'd0, 2'd1, 1, 1, 1);
    endtask

    task automatic t_bad_start;
        cfg_chunk64 = 1'b0;
        send(2'd0, 32'h3FFF_FFE0, 64, 1'b0, 0);
        chk("R9 count", 64'(n), 64'd2);
        chunk("R9 invalid head", 0, 0, 64'hFFFF_FFFF, 2'd0, 2'd1, 1, 1, 0);
        chunk("R9 aperture tail still invalid", 1, 0, 64'hFFFF_FFFF, 2'd0, 2'd1, 1, 1, 1);
    endtask

    task automatic t_smm;
        cfg_chunk64 = 1'b0;
        send(2'd1, 32'h0F00_0000, 4, 1'b1, 0);
        chunk("R3 smm write", 0, 0, 0, 2'd0, 2'd1, 1, 0, 1);
    endtask

    task automatic t_aperture;
        cfg_chunk64 = 1'b0;
        send(2'd0, 32'h4000_0100, 32, 1'b0, 0);
        chunk("R4 aperture read", 0, 32'h4000_0100, 64'hFFFF_FFFF, 2'd0, 2'd0, 0, 0, 1);
        cfg_ap_size = 32'd0;
        send(2'd0, 32'h4000_0100, 32, 1'b0, 0);
        chunk("R4 aperture disabled", 0, 0, 64'hFFFF_FFFF, 2'd0, 2'd1, 1, 1, 1);
        cfg_ap_size = 32'h0100_0000;
    endtask

    task automatic t_gport;
        cfg_chunk64 = 1'b0;
        send(2'd0, 32'h9000_0000, 32, 1'b0, 0);
        chunk("R5 gport read invalid", 0, 0, 64'hFFFF_FFFF, 2'd0, 2'd1, 1, 1, 1);
        send(2'd1, 32'h9000_0040, 32, 1'b1, 0);
        chunk("R5 gport write", 0, 32'h9000_0040, 64'hFFFF_FFFF, 2'd1, 2'd0, 0, 0, 1);
    endtask

    task automatic t_vga;
        cfg_chunk64 = 1'b0;
        cfg_vga_en = 1'b1;
        send(2'd1, 32'h000A_0000, 32, 1'b0, 0);
        chunk("R6 vga enabled", 0, 32'h000A_0000, 64'hFFFF_FFFF, 2'd1, 2'd2, 0, 0, 1);
        cfg_vga_en = 1'b0;
        send(2'd1, 32'h000A_0000, 32, 1'b0, 0);
        chunk("R6 vga disabled", 0, 32'h000A_0000, 64'hFFFF_FFFF, 2'd0, 2'd2, 0, 0, 1);
    endtask

    task automatic t_io;
        cfg_chunk64 = 1'b1;
        send(2'd2, 32'h0000_1000, 4, 1'b0, 0);
        chk("R1 count", 64'(n), 64'd1);
        chunk("R1 io refused", 0, 0, 0, 2'd0, 2'd1, 1, 0, 1);
    endtask

    task automatic t_stall;
        cfg_chunk64 = 1'b1;
        send(2'd0, 32'h0000_2000, 128, 1'b0, 3);
        chk("R11 count", 64'(n), 64'd2);
        chunk("R11 first after stall", 0, 32'h2000, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 2'd0, 0, 0, 0);
        chunk("R11 second", 1, 32'h2040, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 2'd0, 0, 0, 1);
    endtask

    task automatic t_max_len;
        cfg_chunk64 = 1'b0;
        send(2'd0, 32'h0000_3010, 256, 1'b0, 0);
        chk("R7 max len count", 64'(n), 64'd9);
        chunk("R7 max head", 0, 32'h3010, 64'hFFFF_0000, 2'd0, 2'd0, 0, 0, 0);
        for (int i = 1; i < 8; i++)
            chunk("R7 max middle", i, 32'h3000 + 32'(32 * i), 64'hFFFF_FFFF, 2'd0, 2'd0, 0, 0, 0);
        chunk("R7 max tail", 8, 32'h3100, 64'h0000_FFFF, 2'd0, 2'd0, 0, 0, 1);
        cfg_chunk64 = 1'b1;
        send(2'd1, 32'h0000_4000, 256, 1'b1, 0);
        chk("R7 64-byte count", 64'(n), 64'd4);
        chunk("R7 64-byte tail", 3, 32'h40C0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 2'd0, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_main_mem();
        t_cross();
        t_bad_start();
        t_smm();
        t_aperture();
        t_gport();
        t_vga();
        t_io();
        t_stall();
        t_max_len();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule